// File: doc/BRIEF.md
# Tagged Loop Exit Predictor

This block watches resolved conditional branches and picks out those that behave like counted loops: a run of outcomes in one direction (the body), closed by a single outcome in the other direction (the exit), repeated with the same trip count. For such a branch it predicts the body direction on every iteration except the last, where it predicts the exit. It is meant to sit beside a general outcome predictor, which decides whether to use its answer when it reports a hit.

Storage is a two-way set-associative table of 64 sets, 128 entries in all. Each entry holds a tag, the body direction, a learned limit (body iterations per pass) and a running iteration count, both 6 bits wide, and a three-state phase: waiting, training and locked. A branch that misses the table is given an entry only when its outcome flips against the last outcome seen for its set. The entry then counts one whole pass of the loop to learn its limit, and only then reports hits. The lookup port returns a registered hit and prediction one clock after the address is presented. The resolve port allocates, trains and advances entries.

Top module: `loop_pred`

## Requirements
- R1: A synchronous reset clears every entry and the lookup outputs; after reset no address hits until it has been trained again.
- R2: Set index is IP[9:4] and tag is IP[15:10]; other IP bits are ignored. The lookup result for the address driven in one cycle appears on lk_hit/lk_pred after the next rising edge. A hit needs a matching tag in a locked entry. Outcome encoding: 1 = taken, 0 = not taken.
- R3: A resolve that misses allocates an entry only when its outcome differs from the last missing outcome recorded for the same set. The first miss in a set, and misses that repeat that outcome, allocate nothing. The new entry takes the earlier outcome as its body direction.
- R4: A newly allocated entry counts body outcomes and does not hit. At the next exit outcome it stores that count as its limit and becomes locked. A pass with zero body outcomes leaves it training.
- R5: A locked entry predicts the body direction while its count is below the limit, and the exit direction when the count equals the limit. Each resolve that hits increments the count. A correct exit returns it to zero, so the pattern repeats.
- R6: A pass of 64 or more body outcomes during training abandons the attempt with no hit. A pass of exactly 63 body outcomes plus the exit (a 64-iteration trip) is learned and predicted.
- R7: An exit that comes before the count reaches the limit unlocks the entry and starts training from zero at once. The following full pass sets the new limit.
- R8: A body outcome where the exit was predicted unlocks the entry and makes it wait for the next exit before it counts again.
- R9: On a resolve that hits or allocates, that way becomes most recent in its set. An allocation replaces the least recently touched way.
- R10: Two branches with the same index and different tags are held and predicted independently in the two ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_ip | input | 32 | Branch address for lookup |
| lk_hit | output | 1 | Registered: a locked entry matches lk_ip |
| lk_pred | output | 1 | Registered predicted outcome, 1 = taken |
| rs_valid | input | 1 | A resolved conditional branch is presented |
| rs_ip | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Loops are driven with taken bodies and with not-taken bodies and several trip counts. This shows that the direction learned at allocation is kept and the exit is placed at the count, not at a fixed position. Steady same-direction streams and partial passes check that allocation and locking happen only on the flip and the full pass. Short and long passes against a learned limit separate the early-exit and late-exit recovery paths. Passes of 63, 64 and more body outcomes probe the counter boundary. Three branches sharing one set, with a resolve on one of them in between, show which way is chosen for eviction.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int CNT_W = 6;
    localparam int TAG_W = 6;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_TRAIN = 2'd1,
        PH_LOCK  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic             body_dir;
        phase_e           phase;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
    } lp_entry_t;

    // Direction a locked entry expects for its next occurrence.
    function automatic logic entry_guess(lp_entry_t e);
        return (e.cnt == e.lim) ? ~e.body_dir : e.body_dir;
    endfunction

endpackage

// File: rtl/lp_entry_upd.sv
module lp_entry_upd
    import lp_pkg::*;
(
    input  lp_entry_t        ent_q,
    input  logic             hit,
    input  logic             alloc,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             taken,
    output lp_entry_t        ent_d
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic is_body;

    always_comb begin
        is_body = (taken == ent_q.body_dir);
        ent_d   = ent_q;
        if (alloc) begin
            ent_d.vld      = 1'b1;
            ent_d.tag      = new_tag;
            ent_d.body_dir = ~taken;
            ent_d.phase    = PH_TRAIN;
            ent_d.lim      = '0;
            ent_d.cnt      = '0;
        end else if (hit) begin
            unique case (ent_q.phase)
                PH_WAIT: begin
                    if (!is_body) begin
                        ent_d.phase = PH_TRAIN;
                        ent_d.cnt   = '0;
                    end
                end
                PH_TRAIN: begin
                    if (is_body) begin
                        if (ent_q.cnt == CNT_TOP) begin
                            ent_d.phase = PH_WAIT;
                            ent_d.cnt   = '0;
                        end else begin
                            ent_d.cnt = ent_q.cnt + 1'b1;
                        end
                    end else if (ent_q.cnt != '0) begin
                        ent_d.lim   = ent_q.cnt;
                        ent_d.phase = PH_LOCK;
                        ent_d.cnt   = '0;
                    end else begin
                        ent_d.cnt = '0;
                    end
                end
                PH_LOCK: begin
                    if (ent_q.cnt == ent_q.lim) begin
                        ent_d.cnt = '0;
                        if (is_body) begin
                            ent_d.phase = PH_WAIT;
                            ent_d.lim   = '0;
                        end
                    end else if (is_body) begin
                        ent_d.cnt = ent_q.cnt + 1'b1;
                    end else begin
                        ent_d.phase = PH_TRAIN;
                        ent_d.lim   = '0;
                        ent_d.cnt   = '0;
                    end
                end
                default: begin
                    ent_d.phase = PH_WAIT;
                    ent_d.cnt   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lp_alloc_filter.sv
module lp_alloc_filter #(
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [SET_W-1:0] set_idx,
    input  logic             taken,
    output logic             trig,
    output logic             prior
);

    localparam int SETS = 1 << SET_W;

    typedef struct packed {
        logic [SETS-1:0] seen;
        logic [SETS-1:0] dir;
    } flt_t;

    flt_t flt_d, flt_q;

    assign trig  = flt_q.seen[set_idx] && (flt_q.dir[set_idx] != taken);
    assign prior = flt_q.dir[set_idx];

    always_comb begin
        flt_d = flt_q;
        if (upd) begin
            flt_d.seen[set_idx] = 1'b1;
            flt_d.dir[set_idx]  = taken;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= '0;
        else     flt_q <= flt_d;
    end

    // R3
    prior_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && trig) |=> flt_q.dir[$past(set_idx)] == !prior_q_chk_ref)
        else $error("filter direction not updated");

    logic prior_q_chk_ref;
    always_ff @(posedge clk) prior_q_chk_ref <= prior;

endmodule

// File: rtl/loop_pred.sv
module loop_pred
    import lp_pkg::*;
#(
    parameter int IP_W    = 32,
    parameter int IDX_LSB = 4,
    parameter int SET_W   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IP_W-1:0] lk_ip,
    output logic            lk_hit,
    output logic            lk_pred,
    input  logic            rs_valid,
    input  logic [IP_W-1:0] rs_ip,
    input  logic            rs_taken
);

    localparam int SETS    = 1 << SET_W;
    localparam int WAYS    = 2;
    localparam int TAG_LSB = IDX_LSB + SET_W;
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    typedef struct packed {
        lp_entry_t [SETS-1:0][WAYS-1:0] ent;
        logic [SETS-1:0]                lru;
        logic                           lk_hit;
        logic                           lk_pred;
    } st_t;

    st_t st_d, st_q;

    logic [SET_W-1:0] rs_set, lk_set;
    logic [TAG_W-1:0] rs_tag, lk_tag;
    lp_entry_t        rd_ent  [WAYS];
    lp_entry_t        lk_ent  [WAYS];
    lp_entry_t        upd_ent [WAYS];
    logic [WAYS-1:0]  rs_match, lk_match;
    logic             rs_hit, hit_way, victim, alloc;
    logic             trig, prior;
    lp_entry_t        hit_ent;

    assign rs_set = rs_ip[TAG_LSB-1:IDX_LSB];
    assign rs_tag = rs_ip[TAG_MSB:TAG_LSB];
    assign lk_set = lk_ip[TAG_LSB-1:IDX_LSB];
    assign lk_tag = lk_ip[TAG_MSB:TAG_LSB];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign rd_ent[w]   = st_q.ent[rs_set][w];
            assign lk_ent[w]   = st_q.ent[lk_set][w];
            assign rs_match[w] = rd_ent[w].vld && (rd_ent[w].tag == rs_tag);
            assign lk_match[w] = lk_ent[w].vld && (lk_ent[w].tag == lk_tag)
                                 && (lk_ent[w].phase == PH_LOCK);

            lp_entry_upd u_upd (
                .ent_q   (rd_ent[w]),
                .hit     (rs_valid && rs_match[w]),
                .alloc   (alloc && (victim == w[0])),
                .new_tag (rs_tag),
                .taken   (rs_taken),
                .ent_d   (upd_ent[w])
            );

            // R5
            lock_range_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_ent[w].vld && rd_ent[w].phase == PH_LOCK)
                |-> (rd_ent[w].lim != '0 && rd_ent[w].cnt <= rd_ent[w].lim))
                else $error("locked entry count out of range");
        end
    endgenerate

    assign rs_hit  = |rs_match;
    assign hit_way = rs_match[1];
    assign hit_ent = hit_way ? rd_ent[1] : rd_ent[0];
    assign victim  = st_q.lru[rs_set];
    assign alloc   = rs_valid && !rs_hit && trig;

    lp_alloc_filter #(.SET_W(SET_W)) u_flt (
        .clk     (clk),
        .rst     (rst),
        .upd     (rs_valid && !rs_hit),
        .set_idx (rs_set),
        .taken   (rs_taken),
        .trig    (trig),
        .prior   (prior)
    );

    always_comb begin
        st_d         = st_q;
        st_d.lk_hit  = |lk_match;
        st_d.lk_pred = lk_match[1] ? entry_guess(lk_ent[1]) : entry_guess(lk_ent[0]);
        if (rs_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                st_d.ent[rs_set][w] = upd_ent[w];
            end
            if (rs_hit)     st_d.lru[rs_set] = ~hit_way;
            else if (alloc) st_d.lru[rs_set] = ~victim;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lk_hit  = st_q.lk_hit;
    assign lk_pred = st_q.lk_pred;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lk_hit)
        else $error("hit right after reset");

    // R10
    way_unique_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_ent[0].vld && rd_ent[1].vld && rd_ent[0].tag == rd_ent[1].tag))
        else $error("duplicate tag in set");

    // R5
    exit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit && hit_ent.phase == PH_LOCK && hit_ent.cnt == hit_ent.lim
         && rs_taken != hit_ent.body_dir)
        |=> st_q.ent[$past(rs_set)][$past(hit_way)].cnt == '0)
        else $error("count did not wrap after exit");

    // R9
    mru_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit) |=> st_q.lru[$past(rs_set)] != $past(hit_way))
        else $error("touched way left as replacement choice");

    // R3
    alloc_dir_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> st_q.ent[$past(rs_set)][$past(victim)].body_dir == $past(prior))
        else $error("allocated body direction differs from prior outcome");

endmodule

// File: tb/loop_pred_tb_top.sv
module loop_pred_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_ip;
    logic        lk_hit, lk_pred;
    logic        rs_valid;
    logic [31:0] rs_ip;
    logic        rs_taken;
    int          checks = 0;
    int          errs   = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    loop_pred dut_i (
        .clk      (clk),
        .rst      (rst),
        .lk_ip    (lk_ip),
        .lk_hit   (lk_hit),
        .lk_pred  (lk_pred),
        .rs_valid (rs_valid),
        .rs_ip    (rs_ip),
        .rs_taken (rs_taken)
    );

    function automatic logic [31:0] mk(input int tag, input int set);
        return {16'h0, tag[5:0], set[5:0], 4'h0};
    endfunction

    task automatic look(input logic [31:0] ip, input logic eh, input logic ep, input string req);
        @(negedge clk);
        lk_ip = ip;
        @(negedge clk);
        checks++;
        if (lk_hit !== eh || (eh && lk_pred !== ep)) begin
            errs++;
            $display("FAIL %s: hit/pred %b/%b expected %b/%b", req, lk_hit, lk_pred, eh, ep);
        end
    endtask

    task automatic res(input logic [31:0] ip, input logic t);
        @(negedge clk);
        rs_valid = 1'b1;
        rs_ip    = ip;
        rs_taken = t;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    task automatic run_pass(input logic [31:0] ip, input logic dir, input int nbody);
        for (int k = 0; k < nbody; k++) res(ip, dir);
        res(ip, ~dir);
    endtask

    task automatic walk(input logic [31:0] ip, input logic dir, input int lim, input string req);
        for (int k = 0; k <= lim; k++) begin
            look(ip, 1'b1, (k == lim) ? ~dir : dir, req);
            res(ip, (k == lim) ? ~dir : dir);
        end
    endtask

    task automatic t_reset();
        look(mk(1, 3), 1'b0, 1'b0, "R1 reset miss A");
        look(mk(0, 0), 1'b0, 1'b0, "R1 reset miss zero");
    endtask

    task automatic t_train();
        logic [31:0] a = mk(1, 3);
        for (int k = 0; k < 4; k++) res(a, 1'b1);
        look(a, 1'b0, 1'b0, "R3 steady stream not allocated");
        res(a, 1'b0);
        look(a, 1'b0, 1'b0, "R4 allocated but untrained");
        for (int k = 0; k < 4; k++) res(a, 1'b1);
        look(a, 1'b0, 1'b0, "R4 mid training pass");
        res(a, 1'b0);
        look(a, 1'b1, 1'b1, "R4 locked after second pass");
        look(mk(2, 3), 1'b0, 1'b0, "R2 other tag same set");
        look(mk(1, 4), 1'b0, 1'b0, "R2 same tag other set");
        look(a | 32'h0001_000C, 1'b1, 1'b1, "R2 ignored address bits");
    endtask

    task automatic t_predict();
        walk(mk(1, 3), 1'b1, 4, "R5 taken-body pass");
        walk(mk(1, 3), 1'b1, 4, "R5 wrap and repeat");
    endtask

    task automatic t_not_taken();
        logic [31:0] b = mk(5, 7);
        res(b, 1'b0);
        res(b, 1'b0);
        res(b, 1'b1);
        run_pass(b, 1'b0, 2);
        walk(b, 1'b0, 2, "R5 not-taken-body pass");
    endtask

    task automatic t_steady();
        logic [31:0] d = mk(9, 11);
        for (int k = 0; k < 70; k++) res(d, 1'b1);
        look(d, 1'b0, 1'b0, "R3 long steady stream");
    endtask

    task automatic t_overflow();
        logic [31:0] g = mk(4, 20);
        for (int k = 0; k < 3; k++) res(g, 1'b1);
        res(g, 1'b0);
        run_pass(g, 1'b1, 64);
        look(g, 1'b0, 1'b0, "R6 64-body pass abandoned");
        run_pass(g, 1'b1, 64);
        look(g, 1'b0, 1'b0, "R6 64-body pass again");
        run_pass(g, 1'b1, 63);
        look(g, 1'b1, 1'b1, "R6 63-body pass locked");
        for (int k = 0; k < 63; k++) res(g, 1'b1);
        look(g, 1'b1, 1'b0, "R6 exit predicted at 63");
        res(g, 1'b0);
        look(g, 1'b1, 1'b1, "R6 wrap after 63");
    endtask

    task automatic t_early();
        logic [31:0] a = mk(1, 3);
        res(a, 1'b1);
        res(a, 1'b1);
        res(a, 1'b0);
        look(a, 1'b0, 1'b0, "R7 early exit unlocks");
        run_pass(a, 1'b1, 2);
        look(a, 1'b1, 1'b1, "R7 relearned");
        walk(a, 1'b1, 2, "R7 new limit 2");
    endtask

    task automatic t_late();
        logic [31:0] a = mk(1, 3);
        res(a, 1'b1);
        res(a, 1'b1);
        res(a, 1'b1);
        look(a, 1'b0, 1'b0, "R8 late exit unlocks");
        res(a, 1'b1);
        res(a, 1'b0);
        look(a, 1'b0, 1'b0, "R8 waited for exit");
        run_pass(a, 1'b1, 3);
        look(a, 1'b1, 1'b1, "R8 relearned limit 3");
        walk(a, 1'b1, 3, "R8 new limit 3");
    endtask

    task automatic t_replace();
        logic [31:0] x = mk(1, 30);
        logic [31:0] y = mk(2, 30);
        logic [31:0] z = mk(3, 30);
        res(x, 1'b1);
        res(x, 1'b1);
        res(x, 1'b0);
        run_pass(x, 1'b1, 2);
        res(y, 1'b0);
        res(y, 1'b0);
        res(y, 1'b1);
        run_pass(y, 1'b0, 2);
        look(x, 1'b1, 1'b1, "R10 way holding X");
        look(y, 1'b1, 1'b0, "R10 way holding Y");
        res(x, 1'b1);
        res(z, 1'b1);
        res(z, 1'b0);
        look(y, 1'b0, 1'b0, "R9 least recent Y evicted");
        look(x, 1'b1, 1'b1, "R9 recent X kept");
        run_pass(z, 1'b1, 1);
        look(z, 1'b1, 1'b1, "R9 Z trained in freed way");
        res(x, 1'b1);
        look(x, 1'b1, 1'b0, "R10 X exit after Z traffic");
    endtask

    initial begin
        rst      = 1'b1;
        lk_ip    = '0;
        rs_valid = 1'b0;
        rs_ip    = '0;
        rs_taken = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_train();
        t_predict();
        t_not_taken();
        t_steady();
        t_overflow();
        t_early();
        t_late();
        t_replace();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

endmodule